// File: doc/BRIEF.md
# Serial ADC Acquisition Controller

This block is the host-side master for a single 14-bit successive-approximation converter with a three-wire link. The link carries an active-low conversion-start strobe, a busy indication and a serial data line that the host clocks. The controller fires the start strobe at a programmed sample interval. It then waits for the conversion to finish, in one of two ways: it sees busy rise and fall, or it counts a fixed delay when busy is not wired. After that it clocks out one 16-bit frame and hands the 14-bit code downstream on a valid/ready port.

Two operating styles are supported. In the normal style the strobe is a short low pulse and conversion begins on its falling edge. In the sleep style the converter powers down between samples. Its strobe pulse is shaped to stay inside the permitted narrow-width window, and the result is only collected after the wake-up plus conversion delay, counted from the strobe's rising edge. The serial clock stays low outside reads and whenever the strobe falls. Every read ends a fixed quiet interval before the next strobe falling edge.

A format input selects the result coding. In two's complement the 14-bit code is sign-extended to 16 bits; in straight binary it is zero-extended. A busy signal that never completes raises a timeout flag. A result that arrives while the previous one is still unaccepted raises an overrun flag.

Top module: `adc_acq_ctrl`

## Requirements
- R1: In normal mode (sleep_mode=0) each conversion drives convst_n low for exactly START_LOW clock cycles (default 10, 40 ns at 250 MHz). Otherwise convst_n rests high, including after reset.
- R2: Each high phase and each low phase of sclk during a read lasts max(sclk_div, MIN_HALF) clock cycles (MIN_HALF default 8). sclk is 0 after reset, between reads, and at every falling edge of convst_n.
- R3: A read issues exactly 16 sclk pulses. sdata is sampled on each sclk falling edge, most significant bit first. The last 14 bits sampled form the code, so the two leading zeros are discarded.
- R4: With fmt_twos=1, res_data[15:14] both equal code bit 13. With fmt_twos=0, res_data[15:14] are 0. res_data[13:0] is always the code, and res_fmt reports the format used for the result on the port.
- R5: With busy_en=1 the read starts only after busy has been seen high and then low. No sclk rising edge occurs while busy is high.
- R6: With busy_en=0 in normal mode, the first sclk rising edge comes at least NORM_WAIT cycles (default 1250, 5 us) after the convst_n falling edge.
- R7: In sleep mode (sleep_mode=1) convst_n is low for SLEEP_LOW cycles (default 250, 1 us), which lies inside the 10..500-cycle narrow window. With busy_en=0 the first sclk rising edge comes at least SLEEP_WAIT cycles (default 2500, 10 us) after the convst_n rising edge.
- R8: Every convst_n falling edge comes at least QUIET cycles (default 63, 250 ns) after the last sclk falling edge. When the conversion and read fit, consecutive falling edges are exactly `period` cycles apart.
- R9: With busy_en=1, if busy has not completed within busy_lim cycles of the start, timeout_err goes to 1, no sclk pulse is issued and no result is produced. timeout_err returns to 0 at the next start.
- R10: res_valid stays 1 and res_data stays stable until a cycle with res_ready=1. res_valid then drops unless a new result arrives in that same cycle.
- R11: A result that completes while res_valid=1 and res_ready=0 replaces the held data and sets overrun to 1. overrun returns to 0 when a result is accepted.
- R12: While enable=0 no new conversion is started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Permits new conversion starts |
| sleep_mode | input | 1 | 0 = normal style, 1 = power-down-between-samples style |
| busy_en | input | 1 | 1 = wait on busy, 0 = wait a fixed delay |
| fmt_twos | input | 1 | 1 = two's complement, 0 = straight binary |
| period | input | P_W | Sample interval in clock cycles |
| sclk_div | input | D_W | Serial clock half-period in clock cycles |
| busy_lim | input | T_W | Busy timeout in clock cycles from the start |
| busy | input | 1 | Converter busy indication |
| sdata | input | 1 | Serial data from the converter |
| res_ready | input | 1 | Downstream accepts the result |
| convst_n | output | 1 | Active-low conversion start strobe |
| sclk | output | 1 | Serial clock to the converter |
| res_data | output | FRAME_W | Formatted result |
| res_valid | output | 1 | Result valid |
| res_fmt | output | 1 | Format of the held result |
| timeout_err | output | 1 | Busy did not complete in time |
| overrun | output | 1 | Unaccepted result was replaced |

## Verification
The bench targets the edges of each timing rule. It checks that the strobe width is exact, that the serial clock half-phase is clamped when the divider is set too small, and that the read waits for the busy falling edge and not just for any low level. A design that counted one sclk pulse too few or too many would hand out a code shifted by one bit. The bench detects this by comparing result patterns whose top bits differ. It also runs back-to-back sampling with a too-short period: a controller that ignored the quiet gap would fire the strobe while a read had just ended. Finally, it checks the overrun path, where held data must be replaced, and the timeout path, where no serial clock may be issued.

// File: rtl/adc_acq_pkg.sv
package adc_acq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PULSE = 2'd1,
    ST_CONV  = 2'd2,
    ST_READ  = 2'd3
  } acq_state_t;

  localparam int unsigned FRAME_BITS = 16;
  localparam int unsigned CODE_BITS  = 14;
endpackage

// File: rtl/acq_seq.sv
module acq_seq #(
  parameter int unsigned P_W        = 16,
  parameter int unsigned T_W        = 16,
  parameter int unsigned SYNC_N     = 2,
  parameter int unsigned START_LOW  = 10,
  parameter int unsigned SLEEP_LOW  = 250,
  parameter int unsigned NORM_WAIT  = 1250,
  parameter int unsigned SLEEP_WAIT = 2500,
  parameter int unsigned QUIET      = 63
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           enable,
  input  logic           sleep_mode,
  input  logic           busy_en,
  input  logic [P_W-1:0] period,
  input  logic [T_W-1:0] busy_lim,
  input  logic           busy,
  input  logic           rd_done,
  output logic           convst_n,
  output logic           rd_go,
  output logic           tmo_err
);
  import adc_acq_pkg::*;

  localparam int unsigned Q_W = $clog2(QUIET + 1) + 1;
  localparam logic [T_W-1:0] PW_NORM  = T_W'(START_LOW - 1);
  localparam logic [T_W-1:0] PW_SLEEP = T_W'(SLEEP_LOW - 1);
  localparam logic [T_W-1:0] WT_NORM  = T_W'(NORM_WAIT - 1);
  localparam logic [T_W-1:0] WT_SLEEP = T_W'(SLEEP_WAIT - 1);
  localparam logic [Q_W-1:0] Q_MIN    = Q_W'(QUIET);

  acq_state_t st_q, st_d;
  logic              cv_q, cv_d;
  logic [T_W-1:0]    wcnt_q, wcnt_d, tcnt_q, tcnt_d;
  logic [P_W-1:0]    per_q, per_d;
  logic [Q_W-1:0]    q_q, q_d;
  logic              seen_q, seen_d, tmo_q, tmo_d, go_q, go_d;
  logic [SYNC_N-1:0] bsync_q;
  logic              busy_s, start_ok, wait_done;
  logic [T_W-1:0]    pw_last;

  assign busy_s    = bsync_q[SYNC_N-1];
  assign pw_last   = sleep_mode ? PW_SLEEP : PW_NORM;
  assign start_ok  = enable && (q_q >= Q_MIN) &&
                     (({1'b0, per_q} + 1'b1) >= {1'b0, period});
  assign wait_done = sleep_mode ? (wcnt_q >= WT_SLEEP) : (tcnt_q >= WT_NORM);

  always_comb begin
    st_d   = st_q;
    cv_d   = cv_q;
    wcnt_d = (wcnt_q == '1) ? wcnt_q : wcnt_q + 1'b1;
    tcnt_d = (tcnt_q == '1) ? tcnt_q : tcnt_q + 1'b1;
    per_d  = (per_q == '1) ? per_q : per_q + 1'b1;
    q_d    = (q_q == '1) ? q_q : q_q + 1'b1;
    seen_d = seen_q;
    tmo_d  = tmo_q;
    go_d   = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start_ok) begin
          st_d   = ST_PULSE;
          cv_d   = 1'b0;
          wcnt_d = '0;
          tcnt_d = '0;
          per_d  = '0;
          seen_d = 1'b0;
          tmo_d  = 1'b0;
        end
      end
      ST_PULSE: begin
        if (wcnt_q == pw_last) begin
          cv_d   = 1'b1;
          wcnt_d = '0;
          st_d   = ST_CONV;
        end
      end
      ST_CONV: begin
        if (busy_en) begin
          if (busy_s) seen_d = 1'b1;
          if (seen_q && !busy_s) begin
            st_d = ST_READ;
            go_d = 1'b1;
          end else if (tcnt_q >= busy_lim) begin
            tmo_d = 1'b1;
            st_d  = ST_IDLE;
          end
        end else if (wait_done) begin
          st_d = ST_READ;
          go_d = 1'b1;
        end
      end
      ST_READ: begin
        if (rd_done) begin
          q_d  = '0;
          st_d = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cv_q    <= 1'b1;
      wcnt_q  <= '0;
      tcnt_q  <= '0;
      per_q   <= '1;
      q_q     <= '1;
      seen_q  <= 1'b0;
      tmo_q   <= 1'b0;
      go_q    <= 1'b0;
      bsync_q <= '0;
    end else begin
      st_q    <= st_d;
      cv_q    <= cv_d;
      wcnt_q  <= wcnt_d;
      tcnt_q  <= tcnt_d;
      per_q   <= per_d;
      q_q     <= q_d;
      seen_q  <= seen_d;
      tmo_q   <= tmo_d;
      go_q    <= go_d;
      bsync_q <= {bsync_q[SYNC_N-2:0], busy};
    end
  end

  assign convst_n = cv_q;
  assign rd_go    = go_q;
  assign tmo_err  = tmo_q;
endmodule

// File: rtl/acq_sclk_shift.sv
module acq_sclk_shift #(
  parameter int unsigned D_W      = 8,
  parameter int unsigned FRAME_W  = 16,
  parameter int unsigned DATA_W   = 14,
  parameter int unsigned MIN_HALF = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [D_W-1:0]    half_div,
  input  logic              sdata,
  output logic              sclk,
  output logic              done,
  output logic [DATA_W-1:0] code
);
  localparam int unsigned BC_W = $clog2(FRAME_W);
  localparam logic [D_W-1:0]  HALF_MIN = D_W'(MIN_HALF);
  localparam logic [BC_W-1:0] BC_LAST  = BC_W'(FRAME_W - 1);

  logic              act_q, act_d, sclk_q, sclk_d, done_q, done_d;
  logic [D_W-1:0]    hc_q, hc_d, half;
  logic [BC_W-1:0]   bc_q, bc_d;
  logic [DATA_W-1:0] sh_q, sh_d;

  assign half = (half_div < HALF_MIN) ? HALF_MIN : half_div;

  always_comb begin
    act_d  = act_q;
    sclk_d = sclk_q;
    hc_d   = hc_q;
    bc_d   = bc_q;
    sh_d   = sh_q;
    done_d = 1'b0;
    if (go) begin
      act_d  = 1'b1;
      sclk_d = 1'b0;
      hc_d   = '0;
      bc_d   = '0;
    end else if (act_q) begin
      if (hc_q == half - 1'b1) begin
        hc_d = '0;
        if (!sclk_q) begin
          sclk_d = 1'b1;
        end else begin
          sclk_d = 1'b0;
          sh_d   = {sh_q[DATA_W-2:0], sdata};
          if (bc_q == BC_LAST) begin
            act_d  = 1'b0;
            done_d = 1'b1;
          end else begin
            bc_d = bc_q + 1'b1;
          end
        end
      end else begin
        hc_d = hc_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      sclk_q <= 1'b0;
      done_q <= 1'b0;
      hc_q   <= '0;
      bc_q   <= '0;
      sh_q   <= '0;
    end else begin
      act_q  <= act_d;
      sclk_q <= sclk_d;
      done_q <= done_d;
      hc_q   <= hc_d;
      bc_q   <= bc_d;
      sh_q   <= sh_d;
    end
  end

  assign sclk = sclk_q;
  assign done = done_q;
  assign code = sh_q;
endmodule

// File: rtl/acq_out_hold.sv
module acq_out_hold #(
  parameter int unsigned FRAME_W = 16,
  parameter int unsigned DATA_W  = 14
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               new_vld,
  input  logic [DATA_W-1:0]  new_code,
  input  logic               fmt_twos,
  input  logic               ready,
  output logic [FRAME_W-1:0] data,
  output logic               valid,
  output logic               fmt,
  output logic               overrun
);
  logic [FRAME_W-1:0] ext;
  logic [FRAME_W-1:0] data_q, data_d;
  logic               vld_q, vld_d, fmt_q, fmt_d, ovr_q, ovr_d;

  generate
    if (FRAME_W > DATA_W) begin : g_ext
      assign ext = fmt_twos ? {{(FRAME_W-DATA_W){new_code[DATA_W-1]}}, new_code}
                            : {{(FRAME_W-DATA_W){1'b0}}, new_code};
    end else begin : g_flat
      assign ext = new_code;
    end
  endgenerate

  always_comb begin
    data_d = data_q;
    vld_d  = vld_q;
    fmt_d  = fmt_q;
    ovr_d  = ovr_q;
    if (vld_q && ready) begin
      vld_d = 1'b0;
      ovr_d = 1'b0;
    end
    if (new_vld) begin
      data_d = ext;
      fmt_d  = fmt_twos;
      vld_d  = 1'b1;
      if (vld_q && !ready) ovr_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      vld_q  <= 1'b0;
      fmt_q  <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      data_q <= data_d;
      vld_q  <= vld_d;
      fmt_q  <= fmt_d;
      ovr_q  <= ovr_d;
    end
  end

  assign data    = data_q;
  assign valid   = vld_q;
  assign fmt     = fmt_q;
  assign overrun = ovr_q;
endmodule

// File: rtl/adc_acq_ctrl.sv
module adc_acq_ctrl #(
  parameter int unsigned FRAME_W    = adc_acq_pkg::FRAME_BITS,
  parameter int unsigned DATA_W     = adc_acq_pkg::CODE_BITS,
  parameter int unsigned P_W        = 16,
  parameter int unsigned T_W        = 16,
  parameter int unsigned D_W        = 8,
  parameter int unsigned SYNC_N     = 2,
  parameter int unsigned START_LOW  = 10,
  parameter int unsigned SLEEP_LOW  = 250,
  parameter int unsigned NORM_WAIT  = 1250,
  parameter int unsigned SLEEP_WAIT = 2500,
  parameter int unsigned QUIET      = 63,
  parameter int unsigned MIN_HALF   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic               sleep_mode,
  input  logic               busy_en,
  input  logic               fmt_twos,
  input  logic [P_W-1:0]     period,
  input  logic [D_W-1:0]     sclk_div,
  input  logic [T_W-1:0]     busy_lim,
  input  logic               busy,
  input  logic               sdata,
  input  logic               res_ready,
  output logic               convst_n,
  output logic               sclk,
  output logic [FRAME_W-1:0] res_data,
  output logic               res_valid,
  output logic               res_fmt,
  output logic               timeout_err,
  output logic               overrun
);
  logic [1:0]        rs_q;
  logic              rst_i_n;
  logic              rd_go, rd_done;
  logic [DATA_W-1:0] code;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i_n = rs_q[1];

  acq_seq #(
    .P_W(P_W), .T_W(T_W), .SYNC_N(SYNC_N), .START_LOW(START_LOW),
    .SLEEP_LOW(SLEEP_LOW), .NORM_WAIT(NORM_WAIT), .SLEEP_WAIT(SLEEP_WAIT),
    .QUIET(QUIET)
  ) u_seq (
    .clk(clk), .rst_n(rst_i_n), .enable(enable), .sleep_mode(sleep_mode),
    .busy_en(busy_en), .period(period), .busy_lim(busy_lim), .busy(busy),
    .rd_done(rd_done), .convst_n(convst_n), .rd_go(rd_go), .tmo_err(timeout_err)
  );

  acq_sclk_shift #(
    .D_W(D_W), .FRAME_W(FRAME_W), .DATA_W(DATA_W), .MIN_HALF(MIN_HALF)
  ) u_shift (
    .clk(clk), .rst_n(rst_i_n), .go(rd_go), .half_div(sclk_div),
    .sdata(sdata), .sclk(sclk), .done(rd_done), .code(code)
  );

  acq_out_hold #(
    .FRAME_W(FRAME_W), .DATA_W(DATA_W)
  ) u_out (
    .clk(clk), .rst_n(rst_i_n), .new_vld(rd_done), .new_code(code),
    .fmt_twos(fmt_twos), .ready(res_ready), .data(res_data),
    .valid(res_valid), .fmt(res_fmt), .overrun(overrun)
  );
endmodule

// File: rtl/adc_acq_ctrl_chk.sv
module adc_acq_ctrl_chk #(
  parameter int unsigned FRAME_W    = 16,
  parameter int unsigned DATA_W     = 14,
  parameter int unsigned START_LOW  = 10,
  parameter int unsigned QUIET      = 63,
  parameter int unsigned NARROW_MAX = 500,
  parameter int unsigned WIDE_MIN   = 1500
) (
  input logic               clk,
  input logic               rst_n,
  input logic               convst_n,
  input logic               sclk,
  input logic               busy,
  input logic               busy_en,
  input logic               sleep_mode,
  input logic               res_valid,
  input logic               res_ready,
  input logic [FRAME_W-1:0] res_data,
  input logic               res_fmt,
  input logic               rd_done,
  input logic               overrun
);
  localparam int unsigned EXT_N = FRAME_W - DATA_W + 1;

  logic [15:0] low_w, gap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_w <= '0;
      gap   <= '1;
    end else begin
      if (!convst_n) low_w <= (low_w == '1) ? low_w : low_w + 1'b1;
      else           low_w <= '0;
      if (sclk)            gap <= '0;
      else if (gap != '1)  gap <= gap + 1'b1;
    end
  end

  p_start_width_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(convst_n) && !sleep_mode) |-> (low_w == 16'(START_LOW)));

  p_park_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(convst_n) |-> !sclk);

  p_fmt_ext_r4: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_fmt ? ($countones(res_data[FRAME_W-1:DATA_W-1]) == 0 ||
                              $countones(res_data[FRAME_W-1:DATA_W-1]) == EXT_N)
                           : (res_data[FRAME_W-1:DATA_W] == '0)));

  p_no_read_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_en && $rose(sclk)) |-> !busy);

  p_sleep_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(convst_n) && sleep_mode) |->
      ((low_w >= 16'(START_LOW) && low_w <= 16'(NARROW_MAX)) || low_w > 16'(WIDE_MIN)));

  p_quiet_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(convst_n) |-> (gap >= 16'(QUIET)));

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready && !rd_done) |=> (res_valid && $stable(res_data)));

  p_overrun_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_done && res_valid && !res_ready) |=> overrun);
endmodule

bind adc_acq_ctrl adc_acq_ctrl_chk #(
  .FRAME_W(FRAME_W), .DATA_W(DATA_W), .START_LOW(START_LOW), .QUIET(QUIET)
) u_chk (
  .clk(clk), .rst_n(rst_n), .convst_n(convst_n), .sclk(sclk), .busy(busy),
  .busy_en(busy_en), .sleep_mode(sleep_mode), .res_valid(res_valid),
  .res_ready(res_ready), .res_data(res_data), .res_fmt(res_fmt),
  .rd_done(rd_done), .overrun(overrun)
);

// File: tb/adc_acq_ctrl_bench.sv
`timescale 1ns/1ps
module adc_acq_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0, sleep_mode = 1'b0, busy_en = 1'b1, fmt_twos = 1'b1;
  logic [15:0] period = 16'd100;
  logic [7:0]  sclk_div = 8'd8;
  logic [15:0] busy_lim = 16'd1000;
  logic        busy = 1'b0;
  logic        sdata;
  logic        res_ready = 1'b0;
  logic        convst_n, sclk, res_valid, res_fmt, timeout_err, overrun;
  logic [15:0] res_data;

  always #2 clk = ~clk;

  adc_acq_ctrl u_adc_acq_ctrl (
    .clk(clk), .rst_n(rst_n), .enable(enable), .sleep_mode(sleep_mode),
    .busy_en(busy_en), .fmt_twos(fmt_twos), .period(period), .sclk_div(sclk_div),
    .busy_lim(busy_lim), .busy(busy), .sdata(sdata), .res_ready(res_ready),
    .convst_n(convst_n), .sclk(sclk), .res_data(res_data), .res_valid(res_valid),
    .res_fmt(res_fmt), .timeout_err(timeout_err), .overrun(overrun)
  );

  // converter model
  logic [13:0] dev_code = 14'd0;
  logic [15:0] dev_frame = 16'd0;
  bit          dev_busy_on = 1'b1;
  int          dev_conv = 200;
  assign sdata = dev_frame[15];

  always @(negedge convst_n or negedge sclk) begin
    if (!convst_n) dev_frame <= {2'b00, dev_code};
    else           dev_frame <= {dev_frame[14:0], 1'b0};
  end

  always begin
    @(negedge convst_n);
    if (dev_busy_on) begin
      repeat (2) @(posedge clk);
      busy <= 1'b1;
      repeat (dev_conv) @(posedge clk);
      busy <= 1'b0;
    end
  end

  // monitors, sampled away from the active edge
  int  cyc = 0, t_fall = 0, t_rise = 0, t_sfall = -100000;
  int  low_run = 0, last_low = 0, hi_run = 0, last_hi = 0;
  int  n_rise = 0, n_falls = 0, last_int = 0, min_gap = 1 << 30;
  int  dly_fall = 0, dly_rise = 0, viol_busy = 0, viol_park = 0;
  bit  want_first = 0, prev_cv = 1, prev_sc = 0;

  always @(negedge clk) begin
    cyc++;
    if (prev_cv && !convst_n) begin
      n_falls++;
      last_int = cyc - t_fall;
      t_fall = cyc;
      want_first = 1;
      if (sclk || prev_sc) viol_park++;
      if (cyc - t_sfall < min_gap) min_gap = cyc - t_sfall;
    end
    if (!convst_n) low_run++;
    else if (!prev_cv) begin
      last_low = low_run;
      low_run = 0;
      t_rise = cyc;
    end
    if (sclk && !prev_sc) begin
      n_rise++;
      if (want_first) begin
        dly_fall = cyc - t_fall;
        dly_rise = cyc - t_rise;
        want_first = 0;
      end
    end
    if (sclk) hi_run++;
    else if (prev_sc) begin
      last_hi = hi_run;
      hi_run = 0;
      t_sfall = cyc;
    end
    if (sclk && busy) viol_busy++;
    prev_cv = convst_n;
    prev_sc = sclk;
  end

  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(string req, string what, int act, int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic chk_ge(string req, string what, int act, int lo);
    n_tests++;
    if (act < lo) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected >= %0d", req, what, act, lo);
    end
  endtask

  function automatic logic [15:0] expect_word(logic [13:0] c, logic twos);
    return twos ? {{2{c[13]}}, c} : {2'b00, c};
  endfunction

  task automatic wait_valid(string req);
    int k;
    for (k = 0; k < 6000 && !res_valid; k++) @(negedge clk);
    if (!res_valid) chk(req, "result timeout", 0, 1);
  endtask

  task automatic wait_falls(int n);
    int target = n_falls + n;
    for (int k = 0; k < 20000 && n_falls < target; k++) @(negedge clk);
  endtask

  task automatic accept();
    @(negedge clk) res_ready = 1'b1;
    @(negedge clk) res_ready = 1'b0;
  endtask

  task automatic one_conv(logic [13:0] c, string req);
    dev_code = c;
    @(negedge clk) enable = 1'b1;
    wait_falls(1);
    enable = 1'b0;
    wait_valid(req);
  endtask

  task automatic t_reset();
    chk("R1", "convst_n idle", int'(convst_n), 1);
    chk("R2", "sclk idle", int'(sclk), 0);
    chk("R10", "valid after reset", int'(res_valid), 0);
    chk("R9", "timeout after reset", int'(timeout_err), 0);
    chk("R11", "overrun after reset", int'(overrun), 0);
  endtask

  task automatic t_busy_twos();
    int r0 = n_rise;
    busy_en = 1; dev_busy_on = 1; fmt_twos = 1; sclk_div = 8;
    one_conv(14'h2ABC, "R3");
    chk("R3", "data 2ABC twos", int'(res_data), int'(16'hEABC));
    chk("R4", "res_fmt", int'(res_fmt), 1);
    chk("R3", "sclk pulses", n_rise - r0, 16);
    chk("R1", "strobe width", last_low, 10);
    chk("R2", "sclk high phase", last_hi, 8);
    chk("R5", "sclk while busy", viol_busy, 0);
    chk_ge("R5", "read after busy fall", dly_fall, 203);
    accept();
    chk("R10", "valid dropped after accept", int'(res_valid), 0);
  endtask

  task automatic t_formats();
    logic [13:0] codes [4] = '{14'h3FFF, 14'h1FFF, 14'h0000, 14'h2001};
    for (int i = 0; i < 4; i++) begin
      for (int f = 0; f < 2; f++) begin
        fmt_twos = f[0];
        one_conv(codes[i], "R4");
        chk("R4", $sformatf("code %0h fmt %0d", codes[i], f), int'(res_data),
            int'(expect_word(codes[i], f[0])));
        chk("R4", "res_fmt flag", int'(res_fmt), f);
        accept();
      end
    end
  endtask

  task automatic t_div();
    sclk_div = 8'd2;
    one_conv(14'h0155, "R2");
    chk("R2", "clamped high phase", last_hi, 8);
    chk("R3", "data at clamp", int'(res_data), int'(expect_word(14'h0155, fmt_twos)));
    accept();
    sclk_div = 8'd20;
    one_conv(14'h2AAA, "R2");
    chk("R2", "slow high phase", last_hi, 20);
    chk("R3", "data slow clock", int'(res_data), int'(expect_word(14'h2AAA, fmt_twos)));
    accept();
    sclk_div = 8'd8;
  endtask

  task automatic t_no_busy();
    busy_en = 0; dev_busy_on = 0;
    one_conv(14'h1234, "R6");
    chk_ge("R6", "fixed wait before read", dly_fall, 1250);
    chk("R6", "data fixed wait", int'(res_data), int'(expect_word(14'h1234, fmt_twos)));
    accept();
  endtask

  task automatic t_sleep();
    sleep_mode = 1; busy_en = 0; dev_busy_on = 0;
    one_conv(14'h3210, "R7");
    chk("R7", "sleep strobe width", last_low, 250);
    chk_ge("R7", "wait from rising edge", dly_rise, 2500);
    chk("R7", "data sleep", int'(res_data), int'(expect_word(14'h3210, fmt_twos)));
    accept();
    sleep_mode = 0;
  endtask

  task automatic t_timeout();
    int r0 = n_rise;
    busy_en = 1; dev_busy_on = 0; busy_lim = 16'd300;
    @(negedge clk) enable = 1'b1;
    wait_falls(1);
    enable = 1'b0;
    repeat (500) @(negedge clk);
    chk("R9", "timeout flag", int'(timeout_err), 1);
    chk("R9", "no sclk on timeout", n_rise - r0, 0);
    chk("R9", "no result on timeout", int'(res_valid), 0);
    dev_busy_on = 1; busy_lim = 16'd1000;
    dev_code = 14'h0777;
    @(negedge clk) enable = 1'b1;
    wait_falls(1);
    enable = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9", "timeout cleared at start", int'(timeout_err), 0);
    wait_valid("R9");
    accept();
  endtask

  task automatic t_period();
    busy_en = 1; dev_busy_on = 1; res_ready = 1'b1; period = 16'd1500;
    dev_code = 14'h0ABC;
    @(negedge clk) enable = 1'b1;
    wait_falls(3);
    chk("R8", "interval equals period", last_int, 1500);
    period = 16'd100;
    wait_falls(3);
    enable = 1'b0;
    chk_ge("R8", "short period interval", last_int, 101);
    repeat (1000) @(negedge clk);
    res_ready = 1'b0;
    chk_ge("R8", "quiet gap", min_gap, 63);
    chk("R2", "sclk low at strobe fall", viol_park, 0);
  endtask

  task automatic t_overrun();
    busy_en = 1; dev_busy_on = 1; period = 16'd2000; res_ready = 1'b0;
    dev_code = 14'h0111;
    @(negedge clk) enable = 1'b1;
    wait_valid("R11");
    dev_code = 14'h2222;
    for (int k = 0; k < 5000 && !overrun; k++) @(negedge clk);
    enable = 1'b0;
    chk("R11", "overrun set", int'(overrun), 1);
    chk("R11", "newest data kept", int'(res_data), int'(expect_word(14'h2222, fmt_twos)));
    chk("R10", "still valid before accept", int'(res_valid), 1);
    accept();
    chk("R11", "overrun cleared", int'(overrun), 0);
    chk("R10", "valid cleared", int'(res_valid), 0);
    period = 16'd100;
  endtask

  task automatic t_enable_low();
    int f0;
    repeat (2200) @(negedge clk);
    f0 = n_falls;
    enable = 1'b0;
    repeat (3000) @(negedge clk);
    chk("R12", "no starts while disabled", n_falls - f0, 0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_busy_twos();
    t_formats();
    t_div();
    t_no_busy();
    t_sleep();
    t_timeout();
    t_period();
    t_overrun();
    t_enable_low();
    finish_run();
  end
endmodule